// File: doc/BRIEF.md
# Firmware Hub Bus Target Controller

This block is the target side of a nibble-serial boot-memory bus clocked at 33 MHz. It sees a 4-bit data bus and an active-low framing strobe. When the strobe is low with a start code on the bus, it opens a cycle. It then checks an ID-select nibble against a strap input, collects seven address nibbles, and checks a size nibble. After that it runs one single-byte read or one single-byte write. The bus is modelled as three ports: the incoming nibble, the outgoing nibble and an output-enable. The pad tri-state lives outside the block.

Reads fetch one byte through a byte-wide read port that has one cycle of latency. The block returns the byte after two turnaround clocks and a ready sync nibble. Writes produce one address/data pair. The pair goes to a flash-command port when address bit 22 is 1, and to a register-space port when it is 0. Only the low 20 address bits are decoded, or 19 bits in the half-density build. A wrong size nibble makes the block drop the cycle silently. Lowering the strobe mid-cycle aborts the cycle at once. The write strobe is held back until the last data nibble has arrived, so an abort up to that point leaves the downstream side untouched.

Top module: `fwh_target`

## Requirements
- R1: After reset the output enable is low and none of the read, command-write or register-write strobes is asserted.
- R2: Read timing, counting the start nibble as clock 0. `rd_req` is a one-clock pulse in clock 10 with the decoded address. Clocks 10 and 11 are undriven. The block drives 0000 in clock 12, the low data nibble in clock 13, the high nibble in clock 14 and 1111 in clock 15, and floats from clock 16.
- R3: Write timing. The data nibbles arrive in clocks 10 (low) and 11 (high). One write pulse appears in clock 12 with the assembled byte and decoded address. The block drives 0000 in clock 14 and 1111 in clock 15.
- R4: Address bit 22 set to 1 steers a write to `cmd_we` and a read to the core (`rd_reg`=0). Set to 0, it steers a write to `reg_we` and a read to register space (`rd_reg`=1).
- R5: Address bits 27..20 have no effect. The decoded address is the low 20 bits of the 28-bit field, which is sent most significant nibble first.
- R6: With `FULL_DENSITY`=0, bit 19 is also dropped and the decoded address is the low 19 bits.
- R7: A size nibble other than 0000 ends the cycle with no strobe and no bus drive.
- R8: An ID-select nibble that differs from `id_strap` ends the cycle with no strobe and no bus drive.
- R9: The strobe low in a cycle that is not a start releases the bus in that same clock and in the clock after it. It returns the block to idle, and the next cycle runs normally.
- R10: An abort in any clock up to and including clock 11 of a write produces no write strobe.
- R11: An abort in clock 12 or later of a write does not cancel the write pulse that was already issued.
- R12: Output enable is high only in the sync, data and target-turnaround clocks. It is never high while a request strobe is high.
- R13: Start code 1101 opens a read and 1110 opens a write. Any other nibble with the strobe low opens nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_n | input | 1 | Framing strobe, active low |
| bus_in | input | 4 | Nibble seen on the bus |
| bus_out | output | 4 | Nibble the block drives |
| bus_oe | output | 1 | Drive enable for bus_out |
| id_strap | input | 4 | ID-select value this target answers to |
| rd_req | output | 1 | Read request pulse |
| rd_reg | output | 1 | Read targets register space |
| rd_addr | output | DEC_BITS | Decoded read address |
| rd_data | input | 8 | Read byte, valid one clock after rd_req |
| cmd_we | output | 1 | Write pulse to the flash-command port |
| reg_we | output | 1 | Write pulse to register space |
| wr_addr | output | DEC_BITS | Decoded write address |
| wr_data | output | 8 | Write byte |

## Verification
The assertions check the properties that hold every cycle. Request strobes are single-clock pulses and never both high at once. The bus is never driven while a request is pending, and it is released in the clock after any strobe-low. The reset state is quiet. Some behaviour can only be shown by the directed scenarios, because it depends on what the host sent. That covers the exact clock of each nibble, the lowest-nibble-first byte order, the address masking in both density builds, steering by bit 22, and the silent drop on a bad size, bad ID or bad start. It also covers the boundary between an abort that cancels a write and one that comes too late.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    localparam logic [3:0] START_RD   = 4'b1101;
    localparam logic [3:0] START_WR   = 4'b1110;
    localparam logic [3:0] SIZE_BYTE  = 4'b0000;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] TAR_DRIVE  = 4'b1111;

    localparam int ADDR_NIBS  = 7;
    localparam int KEEP_NIBS  = 6;
    localparam int BYTE_NIBS  = 2;
    localparam int SPACE_BIT  = 22;
    localparam int TAR_CLKS   = 2;
    localparam int CNT_W      = 3;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ID,
        PH_ADDR,
        PH_SIZE,
        PH_WLO,
        PH_WHI,
        PH_HTAR,
        PH_SYNC,
        PH_DLO,
        PH_DHI,
        PH_TTAR
    } phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic cap;
        logic addr_en;
        logic data_en;
    } seq_ctl_t;

    function automatic logic is_start(input logic [3:0] nib);
        return (nib == START_RD) || (nib == START_WR);
    endfunction

    function automatic logic target_drives(input phase_e ph);
        return (ph == PH_SYNC) || (ph == PH_DLO) || (ph == PH_DHI) || (ph == PH_TTAR);
    endfunction

    function automatic logic [3:0] drive_nibble(input phase_e ph, input logic [7:0] b);
        case (ph)
            PH_DLO:  return b[3:0];
            PH_DHI:  return b[7:4];
            PH_TTAR: return TAR_DRIVE;
            default: return SYNC_READY;
        endcase
    endfunction

endpackage

// File: rtl/fwh_nib_shift.sv
module fwh_nib_shift #(
    parameter int NIBS      = 2,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [3:0]        nib,
    output logic [4*NIBS-1:0] val
);
    localparam int W = 4 * NIBS;

    generate
        if (MSB_FIRST) begin : g_msb
            always_ff @(posedge clk) begin
                if (rst)     val <= '0;
                else if (en) val <= {val[W-5:0], nib};
            end
        end else begin : g_lsb
            always_ff @(posedge clk) begin
                if (rst)     val <= '0;
                else if (en) val <= {nib, val[W-1:4]};
            end
        end
    endgenerate
endmodule

// File: rtl/fwh_seq.sv
module fwh_seq
    import fwh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strb_n,
    input  logic [3:0] bus_in,
    input  logic [3:0] id_strap,
    output phase_e     phase,
    output seq_ctl_t   ctl
);
    phase_e           nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             is_wr, is_wr_nxt;

    always_comb begin
        nxt       = phase;
        cnt_nxt   = cnt;
        is_wr_nxt = is_wr;
        if (!strb_n) begin
            if (is_start(bus_in)) begin
                nxt       = PH_ID;
                is_wr_nxt = (bus_in == START_WR);
            end else begin
                nxt = PH_IDLE;
            end
            cnt_nxt = '0;
        end else begin
            case (phase)
                PH_ID: begin
                    nxt     = (bus_in == id_strap) ? PH_ADDR : PH_IDLE;
                    cnt_nxt = '0;
                end
                PH_ADDR: begin
                    if (cnt == CNT_W'(ADDR_NIBS - 1)) nxt = PH_SIZE;
                    else                               cnt_nxt = cnt + 1'b1;
                end
                PH_SIZE: begin
                    cnt_nxt = '0;
                    if (bus_in != SIZE_BYTE) nxt = PH_IDLE;
                    else                     nxt = is_wr ? PH_WLO : PH_HTAR;
                end
                PH_WLO: nxt = PH_WHI;
                PH_WHI: begin
                    nxt     = PH_HTAR;
                    cnt_nxt = '0;
                end
                PH_HTAR: begin
                    if (cnt == CNT_W'(TAR_CLKS - 1)) nxt = PH_SYNC;
                    else                              cnt_nxt = cnt + 1'b1;
                end
                PH_SYNC: nxt = is_wr ? PH_TTAR : PH_DLO;
                PH_DLO:  nxt = PH_DHI;
                PH_DHI:  nxt = PH_TTAR;
                PH_TTAR: nxt = PH_IDLE;
                default: nxt = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl         = '0;
        ctl.addr_en = strb_n && (phase == PH_ADDR);
        ctl.data_en = strb_n && ((phase == PH_WLO) || (phase == PH_WHI));
        ctl.rd      = strb_n && (phase == PH_SIZE) && !is_wr && (bus_in == SIZE_BYTE);
        ctl.wr      = strb_n && (phase == PH_WHI);
        ctl.cap     = strb_n && (phase == PH_HTAR) && !is_wr &&
                      (cnt == CNT_W'(TAR_CLKS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            is_wr <= 1'b0;
        end else begin
            phase <= nxt;
            cnt   <= cnt_nxt;
            is_wr <= is_wr_nxt;
        end
    end
endmodule

// File: rtl/fwh_drive.sv
module fwh_drive
    import fwh_pkg::*;
(
    input  phase_e     phase,
    input  logic       strb_n,
    input  logic [7:0] rd_byte,
    output logic [3:0] bus_out,
    output logic       bus_oe
);
    always_comb begin
        bus_oe  = strb_n && target_drives(phase);
        bus_out = bus_oe ? drive_nibble(phase, rd_byte) : 4'b0000;
    end
endmodule

// File: rtl/fwh_target.sv
module fwh_target
    import fwh_pkg::*;
#(
    parameter bit FULL_DENSITY = 1'b1,
    parameter int DEC_BITS     = FULL_DENSITY ? 20 : 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strb_n,
    input  logic [3:0]          bus_in,
    output logic [3:0]          bus_out,
    output logic                bus_oe,
    input  logic [3:0]          id_strap,
    output logic                rd_req,
    output logic                rd_reg,
    output logic [DEC_BITS-1:0] rd_addr,
    input  logic [7:0]          rd_data,
    output logic                cmd_we,
    output logic                reg_we,
    output logic [DEC_BITS-1:0] wr_addr,
    output logic [7:0]          wr_data
);
    localparam int KEEP_W = 4 * KEEP_NIBS;
    localparam int BYTE_W = 4 * BYTE_NIBS;

    phase_e              phase;
    seq_ctl_t            ctl;
    logic [KEEP_W-1:0]   addr_sr;
    logic [BYTE_W-1:0]   data_sr;
    logic [7:0]          rd_byte;
    logic                to_core;
    logic [DEC_BITS-1:0] dec_addr;

    fwh_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .strb_n   (strb_n),
        .bus_in   (bus_in),
        .id_strap (id_strap),
        .phase    (phase),
        .ctl      (ctl)
    );

    fwh_nib_shift #(.NIBS(KEEP_NIBS), .MSB_FIRST(1'b1)) u_addr_sr (
        .clk (clk),
        .rst (rst),
        .en  (ctl.addr_en),
        .nib (bus_in),
        .val (addr_sr)
    );

    fwh_nib_shift #(.NIBS(BYTE_NIBS), .MSB_FIRST(1'b0)) u_data_sr (
        .clk (clk),
        .rst (rst),
        .en  (ctl.data_en),
        .nib (bus_in),
        .val (data_sr)
    );

    fwh_drive u_drive (
        .phase   (phase),
        .strb_n  (strb_n),
        .rd_byte (rd_byte),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    assign to_core  = addr_sr[SPACE_BIT];
    assign dec_addr = addr_sr[DEC_BITS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_req  <= 1'b0;
            rd_reg  <= 1'b0;
            rd_addr <= '0;
            cmd_we  <= 1'b0;
            reg_we  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rd_byte <= '0;
        end else begin
            rd_req <= ctl.rd;
            cmd_we <= ctl.wr && to_core;
            reg_we <= ctl.wr && !to_core;
            if (ctl.rd) begin
                rd_addr <= dec_addr;
                rd_reg  <= !to_core;
            end
            if (ctl.wr) begin
                wr_addr <= dec_addr;
                wr_data <= {bus_in, data_sr[BYTE_W-1:4]};
            end
            if (ctl.cap) rd_byte <= rd_data;
        end
    end
endmodule

// File: rtl/fwh_target_chk.sv
module fwh_target_chk (
    input logic clk,
    input logic rst,
    input logic strb_n,
    input logic bus_oe,
    input logic rd_req,
    input logic cmd_we,
    input logic reg_we
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_oe && !rd_req && !cmd_we && !reg_we));

    p_read_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    p_write_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_we || reg_we) |=> !(cmd_we || reg_we));

    p_write_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_we, reg_we}));

    p_abort_float_r9: assert property (@(posedge clk) disable iff (rst)
        !strb_n |=> !bus_oe);

    p_req_bus_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (rd_req || cmd_we || reg_we) |-> !bus_oe);
endmodule

bind fwh_target fwh_target_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .strb_n (strb_n),
    .bus_oe (bus_oe),
    .rd_req (rd_req),
    .cmd_we (cmd_we),
    .reg_we (reg_we)
);

// File: tb/fwh_target_test.sv
module fwh_target_test;
    localparam int NCYC = 18;
    localparam logic [3:0] ID = 4'h6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strb_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        rd_req, rd_reg, cmd_we, reg_we;
    logic [19:0] rd_addr, wr_addr;
    logic [7:0]  rd_data = 8'h00;
    logic [7:0]  wr_data;

    logic [3:0]  h_out;
    logic        h_oe, h_rr, h_rreg, h_cw, h_rw;
    logic [18:0] h_ra, h_wa;
    logic [7:0]  h_wd;

    int nchk = 0;
    int nerr = 0;

    logic        l_oe [NCYC];
    logic [3:0]  l_out[NCYC];
    logic        l_rr [NCYC];
    logic        l_cw [NCYC];
    logic        l_rw [NCYC];
    logic        l_rreg[NCYC];
    logic [19:0] l_ra [NCYC];
    logic [19:0] l_wa [NCYC];
    logic [7:0]  l_wd [NCYC];
    logic [18:0] l_hwa[NCYC];

    always #2 clk = ~clk;

    fwh_target #(.FULL_DENSITY(1'b1)) uut (
        .clk(clk), .rst(rst), .strb_n(strb_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .id_strap(ID),
        .rd_req(rd_req), .rd_reg(rd_reg), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_we(cmd_we), .reg_we(reg_we), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fwh_target #(.FULL_DENSITY(1'b0)) uut_half (
        .clk(clk), .rst(rst), .strb_n(strb_n), .bus_in(bus_in),
        .bus_out(h_out), .bus_oe(h_oe), .id_strap(ID),
        .rd_req(h_rr), .rd_reg(h_rreg), .rd_addr(h_ra), .rd_data(8'h00),
        .cmd_we(h_cw), .reg_we(h_rw), .wr_addr(h_wa), .wr_data(h_wd)
    );

    // byte memory model: answers one clock after the request
    always @(posedge clk) if (rd_req) rd_data <= rd_addr[7:0] ^ {rd_reg, 7'h25};

    function automatic logic [7:0] mem_val(input logic [27:0] a);
        return a[7:0] ^ {~a[22], 7'h25};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] start, input logic [3:0] id,
                       input logic [27:0] addr, input logic [3:0] size,
                       input logic [7:0] data, input int abort_at);
        for (int k = 0; k < NCYC; k++) begin
            @(negedge clk);
            strb_n = !(k == 0 || k == abort_at);
            if (k == abort_at)   bus_in = 4'hF;
            else if (k == 0)     bus_in = start;
            else if (k == 1)     bus_in = id;
            else if (k <= 8)     bus_in = addr[27 - 4*(k-2) -: 4];
            else if (k == 9)     bus_in = size;
            else if (k == 10 && start == 4'b1110) bus_in = data[3:0];
            else if (k == 11 && start == 4'b1110) bus_in = data[7:4];
            else                 bus_in = 4'hF;
            #1;
            l_oe[k] = bus_oe;  l_out[k] = bus_out; l_rr[k] = rd_req;
            l_cw[k] = cmd_we;  l_rw[k] = reg_we;   l_rreg[k] = rd_reg;
            l_ra[k] = rd_addr; l_wa[k] = wr_addr;  l_wd[k] = wr_data;
            l_hwa[k] = h_wa;
        end
        @(negedge clk);
        strb_n = 1'b1;
        bus_in = 4'hF;
    endtask

    function automatic int activity();
        int n = 0;
        for (int k = 0; k < NCYC; k++) n += int'(l_oe[k]) + int'(l_rr[k]) + int'(l_cw[k]) + int'(l_rw[k]);
        return n;
    endfunction

    function automatic int writes();
        int n = 0;
        for (int k = 0; k < NCYC; k++) n += int'(l_cw[k]) + int'(l_rw[k]);
        return n;
    endfunction

    task automatic t_reset();
        chk(!bus_oe && !rd_req && !cmd_we && !reg_we, "R1", "quiet after reset",
            {bus_oe, rd_req, cmd_we, reg_we}, 0);
    endtask

    task automatic t_read(input logic [27:0] a, input string req);
        logic [7:0] d;
        d = mem_val(a);
        run(4'b1101, ID, a, 4'h0, 8'h00, -1);
        chk(l_rr[10] && !l_rr[9] && !l_rr[11], req, "rd_req pulse clock 10 (R2)", {l_rr[9], l_rr[10], l_rr[11]}, 3'b010);
        chk(l_ra[10] == a[19:0], "R5", "read address low 20 bits", l_ra[10], a[19:0]);
        chk(l_rreg[10] == ~a[22], "R4", "read space steering", l_rreg[10], ~a[22]);
        chk(!l_oe[10] && !l_oe[11] && l_oe[12] && l_out[12] == 4'h0, "R2", "host turnaround then sync",
            {l_oe[10], l_oe[11], l_oe[12], l_out[12]}, 7'b0010000);
        chk(l_oe[13] && l_out[13] == d[3:0], "R2", "low nibble clock 13", l_out[13], d[3:0]);
        chk(l_oe[14] && l_out[14] == d[7:4], "R2", "high nibble clock 14", l_out[14], d[7:4]);
        chk(l_oe[15] && l_out[15] == 4'hF && !l_oe[16], "R2", "target turnaround then float",
            {l_oe[15], l_out[15], l_oe[16]}, 6'b111110);
        chk(activity() == 5, "R12", "drive only in slots 12..15 plus one request", activity(), 5);
    endtask

    task automatic t_write(input logic [27:0] a, input logic [7:0] d);
        run(4'b1110, ID, a, 4'h0, d, -1);
        chk(a[22] ? (l_cw[12] && !l_cw[11] && !l_cw[13]) : (l_rw[12] && !l_rw[13]),
            "R3", "write pulse clock 12", {l_cw[12], l_rw[12]}, {a[22], ~a[22]});
        chk(writes() == 1, "R4", "exactly one write strobe of the steered kind", writes(), 1);
        chk(l_wd[12] == d, "R3", "write byte low nibble first", l_wd[12], d);
        chk(l_wa[12] == a[19:0], "R5", "write address ignores bits 27..20", l_wa[12], a[19:0]);
        chk(l_hwa[12] == a[18:0], "R6", "half density drops bit 19", l_hwa[12], a[18:0]);
        chk(l_oe[14] && l_out[14] == 4'h0 && l_oe[15] && l_out[15] == 4'hF && !l_oe[13] && !l_oe[16],
            "R3", "write sync then turnaround", {l_oe[13], l_oe[14], l_out[14], l_oe[15], l_out[15], l_oe[16]},
            {1'b0, 1'b1, 4'h0, 1'b1, 4'hF, 1'b0});
    endtask

    task automatic t_bad_size();
        run(4'b1110, ID, 28'h0C1_2345, 4'h1, 8'h3C, -1);
        chk(activity() == 0, "R7", "write with size 0001 dropped", activity(), 0);
        run(4'b1101, ID, 28'h0C1_2345, 4'h8, 8'h00, -1);
        chk(activity() == 0, "R7", "read with size 1000 dropped", activity(), 0);
    endtask

    task automatic t_bad_id();
        run(4'b1110, ID ^ 4'h1, 28'h0C1_2345, 4'h0, 8'h3C, -1);
        chk(activity() == 0, "R8", "foreign ID write ignored", activity(), 0);
    endtask

    task automatic t_bad_start();
        run(4'b1010, ID, 28'h0C1_2345, 4'h0, 8'h3C, -1);
        chk(activity() == 0, "R13", "unknown start code ignored", activity(), 0);
    endtask

    task automatic t_abort_read();
        run(4'b1101, ID, 28'h0C0_1234, 4'h0, 8'h00, 13);
        chk(l_oe[12] && !l_oe[13] && !l_oe[14] && !l_oe[15], "R9", "abort releases bus at once",
            {l_oe[12], l_oe[13], l_oe[14], l_oe[15]}, 4'b1000);
        t_read(28'h0C0_0077, "R9");
    endtask

    task automatic t_abort_write();
        run(4'b1110, ID, 28'h0C0_4321, 4'h0, 8'h5A, 11);
        chk(writes() == 0, "R10", "abort on last data nibble cancels write", writes(), 0);
        run(4'b1110, ID, 28'h0C0_4321, 4'h0, 8'h5A, 10);
        chk(writes() == 0, "R10", "abort on first data nibble cancels write", writes(), 0);
        run(4'b1110, ID, 28'h0C0_4321, 4'h0, 8'h5A, 12);
        chk(writes() == 1 && l_cw[12] && l_wd[12] == 8'h5A, "R11", "late abort keeps issued write",
            {writes(), l_wd[12]}, {32'd1, 8'h5A});
        chk(!l_oe[14] && !l_oe[15], "R9", "late abort still releases bus", {l_oe[14], l_oe[15]}, 0);
    endtask

    initial begin
        #800000;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset();
        t_read(28'hABC_0000 | 28'h040_5A3C, "R2");
        t_read(28'h1F0_0000 | 28'h00B_2281, "R13");
        t_write(28'hF4F_9876, 8'hC3);
        t_write(28'h0A8_8E01, 8'h7E);
        t_bad_size();
        t_bad_id();
        t_bad_start();
        t_abort_read();
        t_abort_write();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule